// File: doc/BRIEF.md
# Windowed Comb Multiplier for GF(2^233)

This block multiplies two elements of the binary field GF(2^233), defined by the trinomial f(z) = z^233 + z^74 + 1, and returns the reduced product. Each operand arrives on a 256-bit bus made of four 64-bit words. Bit i of the bus is the coefficient of z^i, and only the low 233 bits have meaning. A caller pulses `start` with both operands present. After a fixed latency the block pulses `done` and presents the reduced product on `prod`, where it stays until the next result.

Inside, the block first builds two 16-entry tables in one cycle. One holds u·b for every 4-bit polynomial u. The other holds u·b·z^4 for every u. Each byte of a word of `a` is then consumed as two nibbles. The low nibble indexes the first table and the high nibble indexes the second, so no 4-bit shift is ever needed. The two selected entries are XORed into a 512-bit accumulator at the word's offset.

The odd-numbered words are handled in one pass of eight byte positions, and the whole accumulator moves up by 8 bits after every position. The even-numbered words are handled in a second pass, which skips the move after its lowest byte. The 465-bit raw product is then folded twice against the trinomial to give the 233-bit result.

Top module: `gf233_comb_mul`

## Requirements
- R1: When `done` pulses, `prod` equals a(z)·b(z) mod (z^233 + z^74 + 1), where bit i of each bus is the coefficient of z^i. This holds for every operand pair, including both all-ones operands.
- R2: Operand bits 233 to 255 are ignored. The result is the one obtained with those bits cleared.
- R3: `done` is high for exactly one cycle. It rises 18 rising edges after the edge that samples `start`.
- R4: Bits 255 down to 233 of `prod` are always zero. `prod` keeps its value between results.
- R5: A `start` pulse that arrives while a multiplication is in progress is ignored. The running result is unchanged, and no extra `done` follows.
- R6: After reset, `done` is low and `prod` is zero.
- R7: A zero operand gives a zero product, and the operand 1 returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a multiplication with the operands present this cycle |
| a_in | input | 256 | Multiplier operand, coefficient of z^i at bit i |
| b_in | input | 256 | Multiplicand operand, coefficient of z^i at bit i |
| done | output | 1 | One-cycle pulse when `prod` carries a new result |
| prod | output | 256 | Reduced product, top 23 bits zero |

## Verification
A wrong table entry, a mis-addressed nibble or a wrong word offset corrupts the partial products of particular coefficients. Sweeping every single-bit multiplier and every single-bit multiplicand against an arithmetic reference exposes such faults on `prod` at the very first `done` of the affected operand. A miscounted byte position, or a shift wrongly applied or skipped at a pass boundary, moves whole bytes of the product. It also shows on the first result, or as a `done` that arrives off the 18-cycle mark. A fault in the fold shows up only when the raw product reaches bit 233, so random and all-ones operands cover it.

// File: rtl/gf_comb_pkg.sv
package gf_comb_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned FIELD_M = 233;
  localparam int unsigned TAP_K   = 74;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_BUILD = 3'd1,
    S_ODD   = 3'd2,
    S_EVEN  = 3'd3,
    S_RED   = 3'd4
  } mul_state_e;
endpackage

// File: rtl/gf_comb_table.sv
module gf_comb_table #(
  parameter int unsigned M  = 233,
  parameter int unsigned TW = M + 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [M-1:0]         b,
  output logic [15:0][TW-1:0]  t_lo,
  output logic [15:0][TW-1:0]  t_hi
);
  logic [15:0][TW-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = '0;
    hi_d = '0;
    for (int u = 0; u < 16; u++) begin
      for (int i = 0; i < 4; i++) begin
        if (((u >> i) & 1) != 0) begin
          lo_d[u] = lo_d[u] ^ (TW'(b) << i);
          hi_d[u] = hi_d[u] ^ (TW'(b) << (i + 4));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_lo <= '0;
      t_hi <= '0;
    end else if (load) begin
      t_lo <= lo_d;
      t_hi <= hi_d;
    end
  end
endmodule

// File: rtl/gf_comb_step.sv
module gf_comb_step #(
  parameter int unsigned W     = 64,
  parameter int unsigned N     = 4,
  parameter int unsigned TW    = 240,
  parameter int unsigned ACC_W = 2 * W * N,
  parameter int unsigned KW    = 3
) (
  input  logic [ACC_W-1:0]       acc,
  input  logic [W*N-1:0]         a,
  input  logic [KW-1:0]          kidx,
  input  logic                   odd_pass,
  input  logic                   do_shift,
  input  logic [15:0][TW-1:0]    t_lo,
  input  logic [15:0][TW-1:0]    t_hi,
  output logic [ACC_W-1:0]       acc_nx
);
  logic [ACC_W-1:0] sum;
  logic [3:0]       nib_lo, nib_hi;

  always_comb begin
    sum    = acc;
    nib_lo = '0;
    nib_hi = '0;
    for (int j = 0; j < N; j++) begin
      if (((j % 2) == 1) == odd_pass) begin
        nib_lo = a[j*W + 8*kidx     +: 4];
        nib_hi = a[j*W + 8*kidx + 4 +: 4];
        sum    = sum ^ (ACC_W'(t_lo[nib_lo] ^ t_hi[nib_hi]) << (W * (j - (j % 2))));
      end
    end
    acc_nx = do_shift ? (sum << 8) : sum;
  end
endmodule

// File: rtl/gf_trinomial_fold.sv
module gf_trinomial_fold #(
  parameter int unsigned M = 233,
  parameter int unsigned K = 74
) (
  input  logic [2*M-2:0] c,
  output logic [M-1:0]   r
);
  localparam int unsigned R1W = M - 1 + K;

  logic [M-2:0]   hi1;
  logic [R1W-1:0] mid;
  logic [K-2:0]   hi2;

  assign hi1 = c[2*M-2:M];
  assign mid = R1W'(c[M-1:0]) ^ R1W'(hi1) ^ (R1W'(hi1) << K);
  assign hi2 = mid[R1W-1:M];
  assign r   = mid[M-1:0] ^ M'(hi2) ^ (M'(hi2) << K);
endmodule

// File: rtl/gf233_comb_mul.sv
module gf233_comb_mul
  import gf_comb_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned N = N_WORDS,
  parameter int unsigned M = FIELD_M,
  parameter int unsigned K = TAP_K
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W*N-1:0] a_in,
  input  logic [W*N-1:0] b_in,
  output logic           done,
  output logic [W*N-1:0] prod
);
  localparam int unsigned OPW   = W * N;
  localparam int unsigned ACC_W = 2 * OPW;
  localparam int unsigned TW    = M + 7;
  localparam int unsigned KW    = $clog2(W / 8);
  localparam int unsigned PW    = 2 * M - 1;
  localparam logic [KW-1:0] KLAST = KW'(W / 8 - 1);
  localparam logic [OPW-1:0] OPMASK = OPW'({M{1'b1}});

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  mul_state_e          st_q, st_d;
  logic [KW-1:0]       kidx_q, kidx_d;
  logic [OPW-1:0]      a_q, b_q;
  logic [ACC_W-1:0]    acc_q, acc_d, acc_step;
  logic [M-1:0]        prod_q, red;
  logic                done_q, done_d;
  logic                cap_en, acc_en, tab_ld, prod_en;
  logic [15:0][TW-1:0] t_lo, t_hi;
  logic                odd_pass, do_shift;

  gf_comb_table #(.M(M), .TW(TW)) u_table (
    .clk   (clk),
    .rst_n (rst_i),
    .load  (tab_ld),
    .b     (b_q[M-1:0]),
    .t_lo  (t_lo),
    .t_hi  (t_hi)
  );

  assign odd_pass = (st_q == S_ODD);
  assign do_shift = odd_pass || (kidx_q != '0);

  gf_comb_step #(.W(W), .N(N), .TW(TW), .ACC_W(ACC_W), .KW(KW)) u_step (
    .acc      (acc_q),
    .a        (a_q),
    .kidx     (kidx_q),
    .odd_pass (odd_pass),
    .do_shift (do_shift),
    .t_lo     (t_lo),
    .t_hi     (t_hi),
    .acc_nx   (acc_step)
  );

  gf_trinomial_fold #(.M(M), .K(K)) u_fold (
    .c (acc_q[PW-1:0]),
    .r (red)
  );

  always_comb begin
    st_d    = st_q;
    kidx_d  = kidx_q;
    acc_d   = acc_step;
    cap_en  = 1'b0;
    acc_en  = 1'b0;
    tab_ld  = 1'b0;
    prod_en = 1'b0;
    done_d  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          st_d   = S_BUILD;
        end
      end
      S_BUILD: begin
        tab_ld = 1'b1;
        acc_en = 1'b1;
        acc_d  = '0;
        kidx_d = KLAST;
        st_d   = S_ODD;
      end
      S_ODD: begin
        acc_en = 1'b1;
        if (kidx_q == '0) begin
          kidx_d = KLAST;
          st_d   = S_EVEN;
        end else begin
          kidx_d = kidx_q - 1'b1;
        end
      end
      S_EVEN: begin
        acc_en = 1'b1;
        if (kidx_q == '0) st_d = S_RED;
        else              kidx_d = kidx_q - 1'b1;
      end
      S_RED: begin
        prod_en = 1'b1;
        done_d  = 1'b1;
        st_d    = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= S_IDLE;
      kidx_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      prod_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kidx_q <= kidx_d;
      done_q <= done_d;
      if (cap_en) begin
        a_q <= a_in & OPMASK;
        b_q <= b_in & OPMASK;
      end
      if (acc_en)  acc_q  <= acc_d;
      if (prod_en) prod_q <= red;
    end
  end

  assign done = done_q;
  assign prod = OPW'(prod_q);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);

  assert_kidx_countdown_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == S_ODD && kidx_q != '0) |=> (kidx_q == $past(kidx_q) - 1'b1));

  assert_busy_ignores_start_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q != S_IDLE) |=> ($stable(a_q) && $stable(b_q)));

  assert_raw_degree_bound_R1: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == S_RED) |-> (acc_q[ACC_W-1:PW] == '0));

  assert_acc_cleared_R1: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == S_BUILD) |=> (acc_q == '0));

  assert_operand_masked_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == S_BUILD) |-> ((a_q[OPW-1:M] == '0) && (b_q[OPW-1:M] == '0)));
endmodule

// File: tb/gf233_comb_mul_test.sv
`timescale 1ns/1ps
module gf233_comb_mul_test;
  localparam int M = 233;
  localparam int OPW = 256;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [OPW-1:0] a_in, b_in;
  logic           done;
  logic [OPW-1:0] prod;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  gf233_comb_mul uut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a_in  (a_in),
    .b_in  (b_in),
    .done  (done),
    .prod  (prod)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [OPW-1:0] mask_m(input logic [OPW-1:0] x);
    logic [OPW-1:0] r;
    for (int i = 0; i < OPW; i++) r[i] = (i < M) ? x[i] : 1'b0;
    return r;
  endfunction

  function automatic logic [OPW-1:0] ref_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic [M:0] r, f, bb;
    f = '0; f[M] = 1'b1; f[74] = 1'b1; f[0] = 1'b1;
    bb = '0;
    for (int i = 0; i < M; i++) bb[i] = b[i];
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[M]) r = r ^ f;
      if (a[i]) r = r ^ bb;
    end
    return OPW'(r[M-1:0]);
  endfunction

  function automatic logic [OPW-1:0] rnd256();
    logic [OPW-1:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [OPW-1:0] pow_z(input int i);
    logic [OPW-1:0] r;
    r = '0;
    r[i] = 1'b1;
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [OPW-1:0] act, input logic [OPW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Start one multiplication, wait for done, check latency, result and pulse width.
  task automatic run_mul(input string tag, input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                         input logic [OPW-1:0] exp, input bit check_lat);
    int cnt;
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    a_in = rnd256(); b_in = rnd256();
    cnt = 0;
    while (1) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done) break;
      if (cnt > 100) break;
    end
    if (cnt > 100) check_int({tag, " watchdog"}, cnt, 18);
    if (check_lat) check_int("R3 latency", cnt, 18);
    check_vec(tag, prod, exp);
    @(negedge clk);
    if (check_lat) check_int("R3 done width", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [OPW-1:0] a, b, held;
    int extra;
    rst_n = 1'b0; start = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: reset state
    check_int("R6 done after reset", int'(done), 0);
    check_vec("R6 prod after reset", prod, '0);

    // R7: zero and one operands
    b = mask_m(rnd256());
    run_mul("R7 zero times b", '0, b, '0, 1);
    run_mul("R7 one times b", pow_z(0), b, b, 1);
    run_mul("R7 b times one", b, pow_z(0), b, 1);
    run_mul("R7 b times zero", b, '0, '0, 0);

    // R1: every single-bit multiplier and multiplicand
    b = mask_m(rnd256());
    for (int i = 0; i < M; i++) run_mul("R1 z^i times b", pow_z(i), b, ref_mul(pow_z(i), b), 0);
    a = mask_m(rnd256());
    for (int i = 0; i < M; i++) run_mul("R1 a times z^i", a, pow_z(i), ref_mul(a, pow_z(i)), 0);

    // R1: all-ones operands and random pairs
    a = mask_m({OPW{1'b1}});
    run_mul("R1 all ones", a, a, ref_mul(a, a), 1);
    for (int n = 0; n < 150; n++) begin
      a = mask_m(rnd256()); b = mask_m(rnd256());
      run_mul("R1 random", a, b, ref_mul(a, b), 0);
    end

    // R2: garbage above bit 232 is ignored
    for (int n = 0; n < 10; n++) begin
      a = rnd256(); b = rnd256();
      a[255] = 1'b1; b[240] = 1'b1;
      run_mul("R2 high bits ignored", a, b, ref_mul(mask_m(a), mask_m(b)), 0);
    end

    // R4: top bits zero and value held between results
    check_vec("R4 top bits zero", prod & ~mask_m({OPW{1'b1}}), '0);
    held = prod;
    repeat (10) @(negedge clk);
    check_vec("R4 prod held", prod, held);

    // R5: start during a running multiplication is ignored
    a = mask_m(rnd256()); b = mask_m(rnd256());
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    a_in = mask_m(rnd256()); b_in = mask_m(rnd256()); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    extra = 0;
    while (!done && extra < 100) begin
      @(negedge clk);
      extra++;
    end
    check_vec("R5 result of first start", prod, ref_mul(a, b));
    extra = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check_int("R5 no extra done", extra, 0);

    finish_run();
  end
endmodule